// File: doc/BRIEF.md
# CAN FD Controller Mode and Timing Configuration Bank

This block is the register bank for a CAN FD controller. Software uses it to pick the operating mode, set the bit-rate-switch and auto-retransmit-disable options, turn the core on, and program the prescaler and segment lengths for both bit-rate phases. The data-phase timing word also holds the transmitter delay compensation settings. The bank turns three mode flags into one operating-mode code for the protocol engine. It passes on an option only in a mode where that option has meaning.

Access is through a plain synchronous bus. A write happens on a clock edge when `we` is high. `rdata` is a combinational view of the word at `addr`. The timing words are locked while the core is enabled. A write with more than one mode flag set is refused and raises an error flag. A self-clearing soft-reset bit puts the whole bank back to its reset state. A status output compares the programmed bit times of the two phases and warns when the data phase is the slower one.

Top module: `canfd_cfg_regs`

## Requirements
- R1: After `rst_n` goes low, every word reads 0, `core_en` is 0, `op_mode` is 0 (normal), and `mode_err` and `rate_slow` are 0.
- R2: The mode word at address 1 holds loopback (bit 0), snoop (bit 1) and sleep (bit 2). `op_mode` decodes these flags as normal=0 (no flag set), sleep=1, loopback=2 and snoop=3. At most one flag is ever stored.
- R3: A mode write with two or more of bits 0..2 set leaves the stored flags, brs and dar unchanged. It sets `mode_err`, which reads back as bit 8 of the mode word. The next legal mode write clears `mode_err`.
- R4: Mode word bit 3 (brs) drives `brs_en` only in normal, sleep and loopback modes. Bit 4 (dar) drives `dar_en` only in normal and sleep modes. Snoop mode enables neither.
- R5: While `core_en` is 0, a write to a timing word (address 2 nominal prescaler, 3 nominal timing, 4 data prescaler, 5 data timing) is stored at that clock edge and appears on the field outputs.
- R6: While `core_en` is 1, writes to addresses 2..5 are ignored, and the readback and field outputs keep their values.
- R7: Writing the control word (address 0) with bit 1 set returns every register to its reset value at that edge, including `core_en` and `mode_err`. Bit 1 always reads 0.
- R8: `rate_slow` is 1 exactly when (dpre+1)*(3+dseg1+dseg2) > (npre+1)*(3+nseg1+nseg2).
- R9: Only defined fields are stored. These are prescalers [7:0]; nominal seg1 [7:0], seg2 [14:8], sjw [22:16]; data seg1 [4:0], seg2 [11:8], sjw [19:16], tdc enable [23], tdc offset [29:24]. Reserved bits and unmapped addresses read 0.
- R10: Bit 0 of the control word sets `core_en` and reads back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address for read and write |
| wdata | input | 32 | Write data |
| we | input | 1 | Write strobe |
| rdata | output | 32 | Read data for `addr` |
| core_en | output | 1 | Core enable |
| op_mode | output | 2 | Decoded operating mode |
| brs_en | output | 1 | Bit-rate switch enable, mode-qualified |
| dar_en | output | 1 | Auto-retransmit disable, mode-qualified |
| mode_err | output | 1 | Last mode write was illegal |
| rate_slow | output | 1 | Data phase bit time exceeds nominal |
| nom_presc | output | 8 | Nominal prescaler |
| nom_seg1 | output | 8 | Nominal segment 1 |
| nom_seg2 | output | 7 | Nominal segment 2 |
| nom_sjw | output | 7 | Nominal sync jump width |
| dat_presc | output | 8 | Data prescaler |
| dat_seg1 | output | 5 | Data segment 1 |
| dat_seg2 | output | 4 | Data segment 2 |
| dat_sjw | output | 4 | Data sync jump width |
| tdc_en | output | 1 | Transmitter delay compensation enable |
| tdc_off | output | 6 | Transmitter delay compensation offset |

## Verification
Every register result, whether a stored field, a mode code, the error flag, a lock that held or a soft reset, is visible on the falling edge after the rising edge that took the write. `rdata` and `rate_slow` settle combinationally in that same cycle. The bench drives each write on a falling edge and releases the strobe on the next one. It then moves `addr` to the word under test and samples one time unit later, well before the next rising edge. The checker properties fire on the cycle after the triggering write.

// File: rtl/canfd_cfg_pkg.sv
package canfd_cfg_pkg;
  localparam int REG_W  = 32;
  localparam int A_CTRL = 0;
  localparam int A_MODE = 1;
  localparam int A_TIM0 = 2;   // first timing word
  localparam int N_TREG = 4;   // nominal prescaler, nominal timing, data prescaler, data timing
  localparam int PRE_W  = 8;
  localparam int NS1_W  = 8;
  localparam int NS2_W  = 7;
  localparam int NSJ_W  = 7;
  localparam int DS1_W  = 5;
  localparam int DS2_W  = 4;
  localparam int DSJ_W  = 4;
  localparam int TDO_W  = 6;
  localparam int BT_W   = 20;  // bit time in clocks: up to 256*385

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_SLEEP  = 2'd1,
    MODE_LOOP   = 2'd2,
    MODE_SNOOP  = 2'd3
  } op_mode_e;

  // storable bits of each timing word
  function automatic logic [REG_W-1:0] treg_mask(input int idx);
    case (idx)
      0, 2:    return 32'h0000_00FF;
      1:       return 32'h007F_7FFF;
      default: return 32'h3F8F_0F1F;
    endcase
  endfunction

  // flags: {sleep, snoop, loopback}
  function automatic op_mode_e decode_mode(input logic [2:0] f);
    if (f[2])      return MODE_SLEEP;
    else if (f[0]) return MODE_LOOP;
    else if (f[1]) return MODE_SNOOP;
    else           return MODE_NORMAL;
  endfunction

  function automatic logic multi_flag(input logic [2:0] f);
    return (f[0] & f[1]) | (f[0] & f[2]) | (f[1] & f[2]);
  endfunction

  // clocks per bit: (prescaler+1) * (sync + seg1+1 + seg2+1)
  function automatic logic [BT_W-1:0] bit_clocks(input logic [PRE_W-1:0] pre,
                                                 input logic [NS1_W-1:0] s1,
                                                 input logic [NS2_W-1:0] s2);
    logic [BT_W-1:0] p, t;
    p = BT_W'(pre) + BT_W'(1);
    t = BT_W'(3) + BT_W'(s1) + BT_W'(s2);
    return p * t;
  endfunction
endpackage

// File: rtl/canfd_lock_reg.sv
module canfd_lock_reg #(
  parameter int           W    = 32,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         wr,
  input  logic         lock,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         wr_taken
);
  assign wr_taken = wr && !lock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q <= '0;
    else if (clr)      q <= '0;
    else if (wr_taken) q <= d & MASK;
  end
endmodule

// File: rtl/canfd_mode_ctl.sv
module canfd_mode_ctl
  import canfd_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       wr,
  input  logic [4:0] wfield,     // {dar, brs, sleep, snoop, loopback}
  output logic [2:0] flags_q,
  output logic       brs_q,
  output logic       dar_q,
  output logic       err_q,
  output op_mode_e   mode,
  output logic       brs_en,
  output logic       dar_en,
  output logic       illegal_evt
);
  assign illegal_evt = wr && multi_flag(wfield[2:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0; brs_q <= 1'b0; dar_q <= 1'b0; err_q <= 1'b0;
    end else if (clr) begin
      flags_q <= '0; brs_q <= 1'b0; dar_q <= 1'b0; err_q <= 1'b0;
    end else if (illegal_evt) begin
      err_q <= 1'b1;
    end else if (wr) begin
      flags_q <= wfield[2:0];
      brs_q   <= wfield[3];
      dar_q   <= wfield[4];
      err_q   <= 1'b0;
    end
  end

  assign mode   = decode_mode(flags_q);
  assign brs_en = brs_q && (mode != MODE_SNOOP);
  assign dar_en = dar_q && (mode == MODE_NORMAL || mode == MODE_SLEEP);
endmodule

// File: rtl/canfd_rate_cmp.sv
module canfd_rate_cmp
  import canfd_cfg_pkg::*;
(
  input  logic [PRE_W-1:0] npre,
  input  logic [NS1_W-1:0] ns1,
  input  logic [NS2_W-1:0] ns2,
  input  logic [PRE_W-1:0] dpre,
  input  logic [DS1_W-1:0] ds1,
  input  logic [DS2_W-1:0] ds2,
  output logic             slow
);
  logic [BT_W-1:0] nom_clk, dat_clk;
  assign nom_clk = bit_clocks(npre, ns1, ns2);
  assign dat_clk = bit_clocks(dpre, NS1_W'(ds1), NS2_W'(ds2));
  assign slow    = dat_clk > nom_clk;
endmodule

// File: rtl/canfd_cfg_regs.sv
module canfd_cfg_regs
  import canfd_cfg_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic              we,
  output logic [REG_W-1:0]  rdata,
  output logic              core_en,
  output logic [1:0]        op_mode,
  output logic              brs_en,
  output logic              dar_en,
  output logic              mode_err,
  output logic              rate_slow,
  output logic [PRE_W-1:0]  nom_presc,
  output logic [NS1_W-1:0]  nom_seg1,
  output logic [NS2_W-1:0]  nom_seg2,
  output logic [NSJ_W-1:0]  nom_sjw,
  output logic [PRE_W-1:0]  dat_presc,
  output logic [DS1_W-1:0]  dat_seg1,
  output logic [DS2_W-1:0]  dat_seg2,
  output logic [DSJ_W-1:0]  dat_sjw,
  output logic              tdc_en,
  output logic [TDO_W-1:0]  tdc_off
);
  // named events for the checker
  logic                    soft_clr;
  logic                    bad_mode_wr;
  logic                    lock_wr_evt;
  logic [N_TREG*REG_W-1:0] tim_all;

  logic             ctrl_wr, mode_wr;
  logic [REG_W-1:0] treg_q [N_TREG];
  logic [N_TREG-1:0] treg_wr, treg_taken;
  logic [2:0]       flags_q;
  logic             brs_q, dar_q;
  op_mode_e         mode_dec;

  assign ctrl_wr  = we && (addr == ADDR_W'(A_CTRL));
  assign mode_wr  = we && (addr == ADDR_W'(A_MODE));
  assign soft_clr = ctrl_wr && wdata[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        core_en <= 1'b0;
    else if (soft_clr) core_en <= 1'b0;
    else if (ctrl_wr)  core_en <= wdata[0];
  end

  canfd_mode_ctl u_mode (
    .clk(clk), .rst_n(rst_n), .clr(soft_clr), .wr(mode_wr),
    .wfield(wdata[4:0]), .flags_q(flags_q), .brs_q(brs_q), .dar_q(dar_q),
    .err_q(mode_err), .mode(mode_dec), .brs_en(brs_en), .dar_en(dar_en),
    .illegal_evt(bad_mode_wr)
  );
  assign op_mode = mode_dec;

  for (genvar g = 0; g < N_TREG; g++) begin : g_treg
    assign treg_wr[g] = we && (addr == ADDR_W'(A_TIM0 + g));
    canfd_lock_reg #(.W(REG_W), .MASK(treg_mask(g))) u_reg (
      .clk(clk), .rst_n(rst_n), .clr(soft_clr), .wr(treg_wr[g]),
      .lock(core_en), .d(wdata), .q(treg_q[g]), .wr_taken(treg_taken[g])
    );
    assign tim_all[g*REG_W +: REG_W] = treg_q[g];
  end
  assign lock_wr_evt = |treg_wr && !(|treg_taken);

  assign nom_presc = treg_q[0][PRE_W-1:0];
  assign nom_seg1  = treg_q[1][7:0];
  assign nom_seg2  = treg_q[1][14:8];
  assign nom_sjw   = treg_q[1][22:16];
  assign dat_presc = treg_q[2][PRE_W-1:0];
  assign dat_seg1  = treg_q[3][4:0];
  assign dat_seg2  = treg_q[3][11:8];
  assign dat_sjw   = treg_q[3][19:16];
  assign tdc_en    = treg_q[3][23];
  assign tdc_off   = treg_q[3][29:24];

  canfd_rate_cmp u_rate (
    .npre(nom_presc), .ns1(nom_seg1), .ns2(nom_seg2),
    .dpre(dat_presc), .ds1(dat_seg1), .ds2(dat_seg2), .slow(rate_slow)
  );

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(A_CTRL))
      rdata = {31'b0, core_en};
    else if (addr == ADDR_W'(A_MODE))
      rdata = {23'b0, mode_err, 3'b0, dar_q, brs_q, flags_q};
    else
      for (int i = 0; i < N_TREG; i++)
        if (addr == ADDR_W'(A_TIM0 + i)) rdata = treg_q[i];
  end
endmodule

// File: rtl/canfd_cfg_regs_chk.sv
module canfd_cfg_regs_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         core_en,
  input logic         lock_wr,
  input logic         soft_clr,
  input logic         bad_mode_wr,
  input logic [1:0]   op_mode,
  input logic         brs_en,
  input logic         dar_en,
  input logic         mode_err,
  input logic [2:0]   flags,
  input logic [127:0] tim_all
);
  // R6
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_wr |=> $stable(tim_all));
  // R3
  bad_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_mode_wr |=> ($stable(op_mode) && mode_err));
  // R7
  soft_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (!core_en && op_mode == 2'd0 && tim_all == '0 && !mode_err));
  // R2
  one_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flags));
  // R4
  brs_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brs_en |-> (op_mode != 2'd3));
  // R4
  dar_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dar_en |-> (op_mode < 2'd2));
endmodule

bind canfd_cfg_regs canfd_cfg_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .core_en(core_en), .lock_wr(lock_wr_evt),
  .soft_clr(soft_clr), .bad_mode_wr(bad_mode_wr), .op_mode(op_mode),
  .brs_en(brs_en), .dar_en(dar_en), .mode_err(mode_err),
  .flags(flags_q), .tim_all(tim_all)
);

// File: tb/tb_canfd_cfg_regs.sv
module tb_canfd_cfg_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic [31:0] rdata;
  logic        core_en, brs_en, dar_en, mode_err, rate_slow, tdc_en;
  logic [1:0]  op_mode;
  logic [7:0]  nom_presc, nom_seg1, dat_presc;
  logic [6:0]  nom_seg2, nom_sjw;
  logic [4:0]  dat_seg1;
  logic [3:0]  dat_seg2, dat_sjw;
  logic [5:0]  tdc_off;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  canfd_cfg_regs dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .we(we), .rdata(rdata),
    .core_en(core_en), .op_mode(op_mode), .brs_en(brs_en), .dar_en(dar_en),
    .mode_err(mode_err), .rate_slow(rate_slow), .nom_presc(nom_presc),
    .nom_seg1(nom_seg1), .nom_seg2(nom_seg2), .nom_sjw(nom_sjw),
    .dat_presc(dat_presc), .dat_seg1(dat_seg1), .dat_seg2(dat_seg2),
    .dat_sjw(dat_sjw), .tdc_en(tdc_en), .tdc_off(tdc_off)
  );

  // {addr, wdata, expected readback, expected op_mode, mode_err, rate_slow}
  localparam int NV = 11;
  localparam logic [71:0] VEC [NV] = '{
    {4'd1, 32'h0000_0004, 32'h0000_0004, 2'd1, 1'b0, 1'b0},  // R2 sleep
    {4'd1, 32'h0000_0019, 32'h0000_0019, 2'd2, 1'b0, 1'b0},  // R2 loopback
    {4'd1, 32'h0000_0003, 32'h0000_0119, 2'd2, 1'b1, 1'b0},  // R3 illegal
    {4'd1, 32'h0000_000A, 32'h0000_000A, 2'd3, 1'b0, 1'b0},  // R2 snoop, R3 clear
    {4'd1, 32'hFFFF_FFE0, 32'h0000_0000, 2'd0, 1'b0, 1'b0},  // R9 reserved
    {4'd2, 32'hABCD_00FF, 32'h0000_00FF, 2'd0, 1'b0, 1'b0},  // R5 R9
    {4'd4, 32'h0000_0FFF, 32'h0000_00FF, 2'd0, 1'b0, 1'b0},  // R8 equal
    {4'd5, 32'h0000_0001, 32'h0000_0001, 2'd0, 1'b0, 1'b1},  // R8 slower
    {4'd3, 32'h0000_0101, 32'h0000_0101, 2'd0, 1'b0, 1'b0},  // R8 faster
    {4'd5, 32'hFFFF_FFFF, 32'h3F8F_0F1F, 2'd0, 1'b0, 1'b1},  // R9 data mask
    {4'd3, 32'hFFFF_FFFF, 32'h007F_7FFF, 2'd0, 1'b0, 1'b0}   // R9 nominal mask
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    chk(req, rdata, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 6; a++) rd_chk("R1 reset readback", 4'(a), 32'h0);
    chk("R1 op_mode", 32'(op_mode), 32'd0);
    chk("R1 core_en/err/slow", {29'b0, core_en, mode_err, rate_slow}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][71:68], VEC[i][67:36]);
      rd_chk("R2/R3/R5/R9 vector readback", VEC[i][71:68], VEC[i][35:4]);
      chk("R2 vector op_mode", 32'(op_mode), 32'(VEC[i][3:2]));
      chk("R3 vector mode_err", 32'(mode_err), 32'(VEC[i][1]));
      chk("R8 vector rate_slow", 32'(rate_slow), 32'(VEC[i][0]));
    end
    chk("R9 tdc fields", {25'b0, tdc_en, tdc_off}, {25'b0, 1'b1, 6'h3F});
    chk("R9 nominal seg outputs", {10'b0, nom_sjw, nom_seg2, nom_seg1}, {10'b0, 7'h7F, 7'h7F, 8'hFF});

    // R10 enable and lock
    wr(4'd0, 32'h0000_0001);
    rd_chk("R10 ctrl readback", 4'd0, 32'h1);
    chk("R10 core_en", 32'(core_en), 32'd1);
    wr(4'd2, 32'h0000_0012);
    rd_chk("R6 locked prescaler", 4'd2, 32'h0000_00FF);
    chk("R6 nom_presc port", 32'(nom_presc), 32'hFF);
    wr(4'd5, 32'h0000_0000);
    rd_chk("R6 locked data timing", 4'd5, 32'h3F8F_0F1F);
    chk("R6 rate_slow unchanged", 32'(rate_slow), 32'd0);

    // R4 option qualification
    wr(4'd1, 32'h0000_0018);
    chk("R4 normal brs/dar", {30'b0, brs_en, dar_en}, 32'b11);
    wr(4'd1, 32'h0000_001C);
    chk("R4 sleep brs/dar", {30'b0, brs_en, dar_en}, 32'b11);
    wr(4'd1, 32'h0000_0019);
    chk("R4 loopback brs/dar", {30'b0, brs_en, dar_en}, 32'b10);
    wr(4'd1, 32'h0000_001A);
    chk("R4 snoop brs/dar", {30'b0, brs_en, dar_en}, 32'b00);
    chk("R2 snoop code", 32'(op_mode), 32'd3);

    // R9 unmapped
    wr(4'd15, 32'hDEAD_BEEF);
    rd_chk("R9 unmapped", 4'd15, 32'h0);

    // R3 illegal under snoop
    wr(4'd1, 32'h0000_0007);
    chk("R3 mode kept", 32'(op_mode), 32'd3);
    rd_chk("R3 err bit", 4'd1, 32'h0000_011A);

    // R7 soft reset
    wr(4'd0, 32'h0000_0003);
    chk("R7 core_en cleared", 32'(core_en), 32'd0);
    chk("R7 mode/err cleared", {29'b0, op_mode, mode_err}, 32'd0);
    rd_chk("R7 ctrl reads 0", 4'd0, 32'h0);
    rd_chk("R7 mode word", 4'd1, 32'h0);
    rd_chk("R7 prescaler", 4'd2, 32'h0);
    rd_chk("R7 data timing", 4'd5, 32'h0);

    // R5 writable again
    wr(4'd2, 32'h0000_0005);
    rd_chk("R5 prescaler accepted", 4'd2, 32'h5);
    chk("R5 nom_presc port", 32'(nom_presc), 32'h5);
    chk("R5 other ports", {dat_presc, 3'b0, dat_seg1, 4'b0, dat_seg2, 4'b0, dat_sjw}, 32'h0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule